// File: doc/BRIEF.md
# Channel Status Block Buffer

This block stores one complete channel status block for both subframe channels of a digital audio link, together with a user data store of the same size. Each store has two copies. The host edits the staging copy through a byte window. The transmit side reads individual bits from the working copy, selected by frame number. At a block start the staging copy moves into the working copy in a single clock cycle. This happens only when the host has changed the staging copy since the last move, and only when no host write burst is in progress. When a move is held off, it waits as pending and goes through at the next block start that is not busy.

When a channel's block is marked as professional format, the block computes the closing check byte of that channel as it moves the block. The host does not have to supply this byte. Reads through the window return either one byte, from a selected channel, or two bytes in a fixed order. The block raises a one-cycle completion strobe after every move, which can drive a status interrupt.

Top module: `csbuf_top`

## Requirements
- R1: After reset, both stores read as zero in every byte, `hostRvalid` and `xferDone` are low, and every transmit bit is 0.
- R2: The window spans byte addresses 0x20 to 0x37, and address 0x20+k selects byte k (0..23) of a channel. A write or read at an address outside this span changes no stored byte and returns no read data.
- R3: In one-byte mode (`twoByteMode`=0), a read request gives `hostRvalid` high in the next cycle. `hostRdata` then holds the channel-B byte if `hostChanB` was 1 at the request, and the channel-A byte otherwise. `hostUser`=1 selects the user store and `hostUser`=0 the channel status store. Writes go to the store and channel selected the same way.
- R4: In two-byte mode, a read request gives the channel-A byte in the next cycle and the channel-B byte in the cycle after that, with `hostRvalid` high in both cycles.
- R5: On a `blockStart` cycle where a window write has happened since the last move and `hostBurst` is low, both staging copies move into the working copies at that clock edge, and `xferDone` is high for exactly the next cycle. With nothing pending, `blockStart` changes nothing and `xferDone` stays low.
- R6: A `blockStart` with `hostBurst` high moves nothing and gives no `xferDone`. The move stays pending and is carried out at the next `blockStart` with `hostBurst` low.
- R7: `txCs[c]` and `txUser[c]` give bit `frameIdx[2:0]` of working byte `frameIdx>>3` for channel c (0=A, 1=B). They give 0 when `frameIdx` is 192 or more.
- R8: When bit 0 of staging byte 0 of a channel status channel is 1 at a move, working byte 23 of that channel receives a CRC instead of staging byte 23. The CRC uses x^8+x^4+x^3+x^2+1 and starts from 0xFF. It is fed bytes 0 to 22 in order, each byte from bit 0 upward, and shifts toward the most significant bit. When that bit is 0, byte 23 is copied unchanged.
- R9: The user store is always copied verbatim, including byte 23, whatever the format bit says.
- R10: A window write on the same edge as a move lands only in the staging copy. The move takes the previous staging contents, and the new write stays pending for the next block start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Window write strobe |
| hostRe | input | 1 | Window read request |
| hostAddr | input | 7 | Window byte address |
| hostWdata | input | 8 | Write data |
| hostChanB | input | 1 | Channel select: 1 selects B, 0 selects A |
| hostUser | input | 1 | Store select: 1 selects user data, 0 selects channel status |
| twoByteMode | input | 1 | Read returns A then B bytes |
| hostBurst | input | 1 | Host write burst in progress |
| hostRdata | output | 8 | Read data |
| hostRvalid | output | 1 | Read data valid |
| blockStart | input | 1 | Block boundary pulse |
| frameIdx | input | 8 | Frame number within the block |
| txCs | output | 2 | Working channel status bit per channel |
| txUser | output | 2 | Working user bit per channel |
| xferDone | output | 1 | Move completed (one-cycle pulse) |

## Verification
The bench targets the edges of the window. A decoder that is off by one would either accept 0x1F or 0x38, or drop 0x37, and the stored bytes then differ from the expected ones. It also checks a block start during a burst and a write on the same edge as a move. A design without a pending flag would lose the held-off move. A design that let the simultaneous write pass through would send a byte early. Byte 23 is checked for one professional and one consumer channel, and for the user store. A wrong preset, polynomial or bit order gives a wrong check byte, and a check byte written into the wrong store corrupts user data. The read tests cover both read orders and both channel selections, so swapped A and B bytes show up directly.

// File: rtl/csbuf_pkg.sv
package csbuf_pkg;
  localparam int CS_BYTES = 24;
  localparam int IDX_W = $clog2(CS_BYTES);
  localparam int ADDR_W = 7;
  localparam logic [ADDR_W-1:0] WIN_BASE = 7'h20;
  localparam logic [7:0] CRC_POLY = 8'h1D;
  localparam logic [7:0] CRC_INIT = 8'hFF;

  typedef struct packed {
    logic wr;
    logic xfer;
    logic wrChanB;
    logic wrUser;
    logic [IDX_W-1:0] wrIdx;
    logic [IDX_W-1:0] rdIdx;
    logic rdUser;
  } ctrlStrb_t;
endpackage

// File: rtl/csbuf_ctrl.sv
module csbuf_ctrl
  import csbuf_pkg::*;
#(
  parameter int BYTES = CS_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic              hostRe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostChanB,
  input  logic              hostUser,
  input  logic              twoByteMode,
  input  logic              hostBurst,
  input  logic              blockStart,
  input  logic [7:0]        rdByteA,
  input  logic [7:0]        rdByteB,
  output ctrlStrb_t         strb,
  output logic [7:0]        hostRdata,
  output logic              hostRvalid,
  output logic              xferDone
);
  localparam logic [ADDR_W-1:0] WIN_END = WIN_BASE + ADDR_W'(BYTES);

  typedef enum logic [1:0] {RD_IDLE, RD_FIRST, RD_SECOND} rdSt_t;

  rdSt_t            rdSt;
  logic [IDX_W-1:0] rdIdxQ;
  logic             rdUserQ;
  logic             rdChanBQ;
  logic             rdTwoQ;
  logic             dirty;
  logic             inWin;
  logic [IDX_W-1:0] idx;
  logic             xferGo;
  logic             rdReq;

  assign inWin  = (hostAddr >= WIN_BASE) && (hostAddr < WIN_END);
  assign idx    = IDX_W'(hostAddr - WIN_BASE);
  assign rdReq  = hostRe && inWin;
  assign xferGo = blockStart && dirty && !hostBurst;

  always_comb begin
    strb.wr      = hostWe && inWin;
    strb.xfer    = xferGo;
    strb.wrChanB = hostChanB;
    strb.wrUser  = hostUser;
    strb.wrIdx   = idx;
    strb.rdIdx   = rdIdxQ;
    strb.rdUser  = rdUserQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdSt     <= RD_IDLE;
      rdIdxQ   <= '0;
      rdUserQ  <= 1'b0;
      rdChanBQ <= 1'b0;
      rdTwoQ   <= 1'b0;
      dirty    <= 1'b0;
      xferDone <= 1'b0;
    end else begin
      xferDone <= xferGo;
      if (hostWe && inWin) dirty <= 1'b1;
      else if (xferGo)     dirty <= 1'b0;
      if (rdReq) begin
        rdSt     <= RD_FIRST;
        rdIdxQ   <= idx;
        rdUserQ  <= hostUser;
        rdChanBQ <= hostChanB;
        rdTwoQ   <= twoByteMode;
      end else if (rdSt == RD_FIRST && rdTwoQ) begin
        rdSt <= RD_SECOND;
      end else begin
        rdSt <= RD_IDLE;
      end
    end
  end

  always_comb begin
    hostRvalid = (rdSt != RD_IDLE);
    case (rdSt)
      RD_FIRST:  hostRdata = (rdTwoQ || !rdChanBQ) ? rdByteA : rdByteB;
      RD_SECOND: hostRdata = rdByteB;
      default:   hostRdata = 8'h00;
    endcase
  end

  // R5: a completion strobe only follows an unblocked block start
  p_done_after_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> ($past(blockStart) && !$past(hostBurst)));

  // R6: a busy host holds off the move
  p_busy_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (blockStart && hostBurst) |=> !xferDone);

  // R3: a window read answers in the next cycle
  p_read_answer_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> hostRvalid);

  // R4: a two-byte read keeps valid for its second byte
  p_second_byte_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdSt == RD_FIRST && rdTwoQ) |=> hostRvalid);
endmodule

// File: rtl/csbuf_data.sv
module csbuf_data
  import csbuf_pkg::*;
#(
  parameter int BYTES = CS_BYTES,
  localparam int FRAMES = BYTES * 8,
  localparam int FIDX_W = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [7:0]        hostWdata,
  input  logic [FIDX_W-1:0] frameIdx,
  output logic [7:0]        rdByteA,
  output logic [7:0]        rdByteB,
  output logic [1:0]        txCs,
  output logic [1:0]        txUser
);
  logic [1:0][BYTES-1:0][7:0] eCs, eUs, fCs, fUs;
  logic [1:0][7:0]            crcVal;
  logic [1:0]                 isPro;
  logic                       inRange;
  logic [FIDX_W-4:0]          byteSel;

  function automatic logic [7:0] blockCrc(input logic [BYTES-1:0][7:0] blk);
    logic [7:0] c;
    logic       fb;
    c = CRC_INIT;
    for (int i = 0; i < BYTES - 1; i++) begin
      for (int b = 0; b < 8; b++) begin
        fb = c[7] ^ blk[i][b];
        c  = {c[6:0], 1'b0};
        if (fb) c = c ^ CRC_POLY;
      end
    end
    return c;
  endfunction

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    always_comb begin
      crcVal[ch] = blockCrc(eCs[ch]);
      isPro[ch]  = eCs[ch][0][0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eCs <= '0;
      eUs <= '0;
      fCs <= '0;
      fUs <= '0;
    end else begin
      if (strb.wr) begin
        if (strb.wrUser) eUs[strb.wrChanB][strb.wrIdx] <= hostWdata;
        else             eCs[strb.wrChanB][strb.wrIdx] <= hostWdata;
      end
      if (strb.xfer) begin
        fUs <= eUs;
        for (int ch = 0; ch < 2; ch++) begin
          fCs[ch] <= eCs[ch];
          if (isPro[ch]) fCs[ch][BYTES-1] <= crcVal[ch];
        end
      end
    end
  end

  always_comb begin
    rdByteA = strb.rdUser ? eUs[0][strb.rdIdx] : eCs[0][strb.rdIdx];
    rdByteB = strb.rdUser ? eUs[1][strb.rdIdx] : eCs[1][strb.rdIdx];
  end

  assign inRange = (frameIdx < FIDX_W'(FRAMES));
  assign byteSel = frameIdx[FIDX_W-1:3];

  for (genvar ch = 0; ch < 2; ch++) begin : g_tx
    assign txCs[ch]   = inRange ? fCs[ch][byteSel][frameIdx[2:0]] : 1'b0;
    assign txUser[ch] = inRange ? fUs[ch][byteSel][frameIdx[2:0]] : 1'b0;
  end

  // R5: the working copy moves only on a transfer
  p_work_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.xfer |=> ($stable(fCs) && $stable(fUs)));

  // R2: the staging copy changes only through a window write
  p_stage_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wr |=> ($stable(eCs) && $stable(eUs)));

  // R9: the user store arrives unchanged
  p_user_copy_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.xfer |=> (fUs == $past(eUs)));
endmodule

// File: rtl/csbuf_top.sv
module csbuf_top
  import csbuf_pkg::*;
#(
  parameter int BYTES = CS_BYTES,
  localparam int FIDX_W = $clog2(BYTES * 8)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic              hostRe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        hostWdata,
  input  logic              hostChanB,
  input  logic              hostUser,
  input  logic              twoByteMode,
  input  logic              hostBurst,
  output logic [7:0]        hostRdata,
  output logic              hostRvalid,
  input  logic              blockStart,
  input  logic [FIDX_W-1:0] frameIdx,
  output logic [1:0]        txCs,
  output logic [1:0]        txUser,
  output logic              xferDone
);
  ctrlStrb_t  strb;
  logic [7:0] rdByteA, rdByteB;

  csbuf_ctrl #(.BYTES(BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostRe(hostRe),
    .hostAddr(hostAddr), .hostChanB(hostChanB), .hostUser(hostUser),
    .twoByteMode(twoByteMode), .hostBurst(hostBurst), .blockStart(blockStart),
    .rdByteA(rdByteA), .rdByteB(rdByteB), .strb(strb),
    .hostRdata(hostRdata), .hostRvalid(hostRvalid), .xferDone(xferDone)
  );

  csbuf_data #(.BYTES(BYTES)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .hostWdata(hostWdata),
    .frameIdx(frameIdx), .rdByteA(rdByteA), .rdByteB(rdByteB),
    .txCs(txCs), .txUser(txUser)
  );
endmodule

// File: tb/sim_csbuf_top.sv
module sim_csbuf_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWe = 0, hostRe = 0, hostChanB = 0, hostUser = 0;
  logic twoByteMode = 0, hostBurst = 0, blockStart = 0;
  logic [6:0] hostAddr = '0;
  logic [7:0] hostWdata = '0;
  logic [7:0] frameIdx = '0;
  logic [7:0] hostRdata;
  logic hostRvalid, xferDone;
  logic [1:0] txCs, txUser;

  int nChecks = 0;
  int nFails = 0;
  logic [7:0] mE [2][2][24];
  logic [7:0] mF [2][2][24];

  always #10 clk = ~clk;

  csbuf_top u0 (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostRe(hostRe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostChanB(hostChanB), .hostUser(hostUser),
    .twoByteMode(twoByteMode), .hostBurst(hostBurst), .hostRdata(hostRdata),
    .hostRvalid(hostRvalid), .blockStart(blockStart), .frameIdx(frameIdx),
    .txCs(txCs), .txUser(txUser), .xferDone(xferDone)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] refCrc(input int ch);
    logic [7:0] c;
    logic fb;
    c = 8'hFF;
    for (int i = 0; i < 23; i++)
      for (int b = 0; b < 8; b++) begin
        fb = c[7] ^ mE[0][ch][i][b];
        c = {c[6:0], 1'b0};
        if (fb) c = c ^ 8'h1D;
      end
    return c;
  endfunction

  task automatic modelMove();
    for (int u = 0; u < 2; u++)
      for (int c = 0; c < 2; c++)
        for (int i = 0; i < 24; i++) mF[u][c][i] = mE[u][c][i];
    for (int c = 0; c < 2; c++)
      if (mE[0][c][0][0]) mF[0][c][23] = refCrc(c);
  endtask

  task automatic wrByte(input logic [6:0] a, input logic [7:0] d, input logic chB, input logic usr);
    @(negedge clk);
    hostWe = 1; hostAddr = a; hostWdata = d; hostChanB = chB; hostUser = usr;
    @(negedge clk);
    hostWe = 0;
    if (a >= 7'h20 && a <= 7'h37) mE[usr][chB][a - 7'h20] = d;
  endtask

  task automatic rdOne(input logic [6:0] a, input logic chB, input logic usr,
                       output logic v, output logic [7:0] d);
    @(negedge clk);
    hostRe = 1; hostAddr = a; hostChanB = chB; hostUser = usr; twoByteMode = 0;
    @(negedge clk);
    hostRe = 0;
    v = hostRvalid; d = hostRdata;
  endtask

  task automatic pulseStart(input logic busy, output logic done);
    @(negedge clk);
    blockStart = 1; hostBurst = busy;
    @(negedge clk);
    blockStart = 0; hostBurst = 0;
    done = xferDone;
  endtask

  task automatic fByte(input int ch, input logic usr, input int idx, output logic [7:0] v);
    for (int b = 0; b < 8; b++) begin
      frameIdx = 8'(idx * 8 + b);
      #1;
      v[b] = usr ? txUser[ch] : txCs[ch];
    end
  endtask

  task automatic checkWork(input string req);
    logic [7:0] v;
    for (int u = 0; u < 2; u++)
      for (int c = 0; c < 2; c++)
        for (int i = 0; i < 24; i++) begin
          fByte(c, u[0], i, v);
          chk(req, v, mF[u][c][i]);
        end
  endtask

  task automatic tReset();
    logic v; logic [7:0] d;
    chk("R1 rvalid", hostRvalid, 0);
    chk("R1 xferDone", xferDone, 0);
    checkWork("R1 working zero");
    rdOne(7'h2A, 1, 1, v, d);
    chk("R1 staging zero", d, 0);
  endtask

  task automatic tWindow();
    logic v; logic [7:0] d;
    wrByte(7'h1F, 8'hA5, 0, 0);
    wrByte(7'h38, 8'h5A, 0, 0);
    rdOne(7'h20, 0, 0, v, d);
    chk("R2 below window no write", d, 0);
    rdOne(7'h37, 0, 0, v, d);
    chk("R2 above window no write", d, 0);
    rdOne(7'h38, 0, 0, v, d);
    chk("R2 read outside no valid", v, 0);
    wrByte(7'h20, 8'h3C, 0, 0);
    wrByte(7'h37, 8'hC3, 0, 0);
    rdOne(7'h20, 0, 0, v, d);
    chk("R2 first byte", d, 8'h3C);
    rdOne(7'h37, 0, 0, v, d);
    chk("R2 last byte", d, 8'hC3);
  endtask

  task automatic tOneByte();
    logic v; logic [7:0] d;
    wrByte(7'h25, 8'h11, 0, 0);
    wrByte(7'h25, 8'h22, 1, 0);
    wrByte(7'h25, 8'h33, 0, 1);
    wrByte(7'h25, 8'h44, 1, 1);
    rdOne(7'h25, 0, 0, v, d);
    chk("R3 valid", v, 1);
    chk("R3 chan A cs", d, 8'h11);
    rdOne(7'h25, 1, 0, v, d);
    chk("R3 chan B cs", d, 8'h22);
    rdOne(7'h25, 0, 1, v, d);
    chk("R3 chan A user", d, 8'h33);
    rdOne(7'h25, 1, 1, v, d);
    chk("R3 chan B user", d, 8'h44);
  endtask

  task automatic tTwoByte();
    @(negedge clk);
    hostRe = 1; hostAddr = 7'h25; hostChanB = 1; hostUser = 0; twoByteMode = 1;
    @(negedge clk);
    hostRe = 0; twoByteMode = 0;
    chk("R4 first valid", hostRvalid, 1);
    chk("R4 A byte first", hostRdata, 8'h11);
    @(negedge clk);
    chk("R4 second valid", hostRvalid, 1);
    chk("R4 B byte second", hostRdata, 8'h22);
    @(negedge clk);
    chk("R4 ends", hostRvalid, 0);
  endtask

  task automatic tMove();
    logic done;
    for (int i = 0; i < 24; i++) begin
      wrByte(7'(8'h20 + i), 8'(i * 7 + 2), 0, 0);
      wrByte(7'(8'h20 + i), 8'(i * 13 + 8), 1, 0);
    end
    pulseStart(0, done);
    modelMove();
    chk("R5 done pulse", done, 1);
    @(negedge clk);
    chk("R5 done one cycle", xferDone, 0);
    checkWork("R5 R7 working copy");
    pulseStart(0, done);
    chk("R5 nothing pending", done, 0);
  endtask

  task automatic tRange();
    frameIdx = 8'd192; #1;
    chk("R7 frame 192", {txCs, txUser}, 0);
    frameIdx = 8'd255; #1;
    chk("R7 frame 255", {txCs, txUser}, 0);
  endtask

  task automatic tBurst();
    logic done; logic [7:0] v;
    wrByte(7'h23, 8'hE7, 0, 0);
    pulseStart(1, done);
    chk("R6 busy no done", done, 0);
    fByte(0, 0, 3, v);
    chk("R6 working unchanged", v, mF[0][0][3]);
    pulseStart(0, done);
    modelMove();
    chk("R6 retried", done, 1);
    fByte(0, 0, 3, v);
    chk("R6 working updated", v, 8'hE7);
  endtask

  task automatic tPro();
    logic done;
    wrByte(7'h20, 8'h01, 0, 0);
    wrByte(7'h20, 8'h02, 1, 0);
    wrByte(7'h37, 8'h5A, 1, 0);
    wrByte(7'h37, 8'h99, 0, 0);
    wrByte(7'h37, 8'h77, 0, 1);
    pulseStart(0, done);
    modelMove();
    chk("R8 done", done, 1);
    checkWork("R8 R9 check byte and user copy");
  endtask

  task automatic tSameEdge();
    logic done; logic [7:0] v;
    wrByte(7'h2B, 8'h10, 1, 0);
    @(negedge clk);
    blockStart = 1; hostWe = 1; hostAddr = 7'h2C; hostWdata = 8'hBE; hostChanB = 1; hostUser = 0;
    @(negedge clk);
    blockStart = 0; hostWe = 0;
    modelMove();
    mE[0][1][12] = 8'hBE;
    chk("R10 done", xferDone, 1);
    fByte(1, 0, 12, v);
    chk("R10 old byte moved", v, mF[0][1][12]);
    fByte(1, 0, 11, v);
    chk("R10 earlier write moved", v, 8'h10);
    pulseStart(0, done);
    modelMove();
    chk("R10 still pending", done, 1);
    fByte(1, 0, 12, v);
    chk("R10 new byte moved", v, 8'hBE);
  endtask

  initial begin
    for (int u = 0; u < 2; u++)
      for (int c = 0; c < 2; c++)
        for (int i = 0; i < 24; i++) begin mE[u][c][i] = 0; mF[u][c][i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tWindow();
    tOneByte();
    tTwoByte();
    tMove();
    tRange();
    tBurst();
    tPro();
    tSameEdge();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule